// File: doc/BRIEF.md
# Level-Prioritized Interrupt Controller

This block gathers twenty level-sensitive interrupt request lines from peripheral modules. It gives each line a programmable 3-bit priority and presents one request to the processor core. That request carries the priority level and a fixed vector number of the most urgent pending line. Each line's priority sits in a bank of 16-bit registers, two lines per register. Software reaches the bank through a small register port with a select, a write strobe, an address and write data. Read data comes back in the same cycle.

Arbitration runs every clock over the request inputs and the stored levels. The chosen line is captured in output registers, so the core sees a change one cycle after it happens. A priority of zero removes a line from arbitration. Because requests are sensed by level, a line that is still high after its handler ends wins again with no new edge. The block also models the core's acceptance decision. It compares the presented level against the core's current interrupt mask level and raises an accept signal only when the presented level is strictly higher.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every one of the 20 priority fields reads 0, and `irq_req` is 0.
- R2: In a level register, source 2k uses bits 2:0 and source 2k+1 uses bits 10:8. Every other bit reads 0, and writing it changes nothing.
- R3: The register for sources 2k and 2k+1 is at address 0x4306 + 2k, for k = 0 to 9. An odd address, or an address outside 0x4306..0x4318, reads 0, and a write to it changes no level.
- R4: A source whose level is 0 is never presented, and `irq_lvl` is never 0 while `irq_req` is 1.
- R5: Among the sources with a high input and a nonzero level, the highest level wins. Between equal levels, the lowest source number wins.
- R6: The vector presented for source n is VEC_BASE + n, with VEC_BASE = 16 by default.
- R7: A source whose input stays high keeps being presented on every cycle it remains the winner. No new edge is needed.
- R8: `irq_take` is 1 exactly when `irq_req` is 1 and `irq_lvl` is strictly greater than `core_il`.
- R9: `irq_req`, `irq_lvl` and `irq_vec` are registered. After each clock edge they reflect the inputs and levels that held before that edge. With no winner, all three are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 20 | Level-sensitive request lines, bit n = source n |
| reg_sel | input | 1 | Register access select |
| reg_wr | input | 1 | Write strobe, used with `reg_sel` |
| reg_addr | input | 16 | Register byte address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, valid in the same cycle while `reg_sel` is 1 |
| core_il | input | 3 | Core's current interrupt mask level |
| irq_req | output | 1 | Request toward the core |
| irq_lvl | output | 3 | Level of the presented source |
| irq_vec | output | 8 | Vector number of the presented source |
| irq_take | output | 1 | Core-side acceptance result |

## Verification
A register write that changes a level can land in the same cycle as arbitration that depends on that level. The stimulus provokes this on purpose: random writes to valid and invalid addresses are interleaved with random request patterns on almost every cycle. The bench model applies each write only after the edge at which the design captures its arbitration result. Each output is therefore judged against the levels that held before the write. The new level must show up one cycle later. The read data in the write cycle's successor must already show the new value.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int          NSRC     = 20,
  parameter int          LVLW     = 3,
  parameter int          VECW     = 8,
  parameter int          VEC_BASE = 16,
  parameter int          AW       = 16,
  parameter int          DW       = 16,
  parameter logic [15:0] REG_BASE = 16'h4306
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic            reg_sel,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic [LVLW-1:0] core_il,
  output logic            irq_req,
  output logic [LVLW-1:0] irq_lvl,
  output logic [VECW-1:0] irq_vec,
  output logic            irq_take
);

  localparam int NREG = (NSRC + 1) / 2;
  localparam int HI_POS = DW / 2;
  localparam int IDXW = $clog2(NSRC);
  localparam logic [DW-1:0] RD_MASK =
    (DW'((1 << LVLW) - 1)) | (DW'((1 << LVLW) - 1) << HI_POS);

  logic [LVLW-1:0] lvl_q [NSRC];

  logic [AW-1:0] offs, ridx;
  logic          hit, wr_en;

  assign offs  = reg_addr - AW'(REG_BASE);
  assign ridx  = offs >> 1;
  assign hit   = !offs[0] && (ridx < AW'(NREG));
  assign wr_en = reg_sel && reg_wr && hit;

  for (genvar i = 0; i < NSRC; i++) begin : g_lvl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lvl_q[i] <= '0;
      else if (wr_en && ridx == AW'(i / 2))
        lvl_q[i] <= reg_wdata[(i % 2) * HI_POS +: LVLW];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_sel && hit)
      for (int i = 0; i < NSRC; i++)
        if (ridx == AW'(i / 2))
          reg_rdata[(i % 2) * HI_POS +: LVLW] = lvl_q[i];
  end

  logic [LVLW-1:0] best_lvl;
  logic [IDXW-1:0] best_idx;

  always_comb begin
    best_lvl = '0;
    best_idx = '0;
    for (int i = 0; i < NSRC; i++)
      if (irq_in[i] && lvl_q[i] > best_lvl) begin
        best_lvl = lvl_q[i];
        best_idx = IDXW'(i);
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req <= 1'b0;
      irq_lvl <= '0;
      irq_vec <= '0;
    end else begin
      irq_req <= best_lvl != '0;
      irq_lvl <= best_lvl;
      irq_vec <= (best_lvl != '0) ? VECW'(VEC_BASE) + VECW'(best_idx) : '0;
    end
  end

  assign irq_take = irq_req && (irq_lvl > core_il);

  assert_lvl_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_lvl != '0);

  assert_vec_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec >= VECW'(VEC_BASE)) && (irq_vec < VECW'(VEC_BASE + NSRC)));

  assert_idle_after_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_in) == '0) |-> !irq_req);

  assert_take_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> irq_req);

  assert_unused_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~RD_MASK) == '0);

endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  localparam int NSRC = 20;
  localparam int VB = 16;
  localparam logic [15:0] BASE = 16'h4306;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_n;
  logic [NSRC-1:0] irq_in;
  logic            reg_sel, reg_wr;
  logic [15:0]     reg_addr, reg_wdata, reg_rdata;
  logic [2:0]      core_il, irq_lvl;
  logic            irq_req, irq_take;
  logic [7:0]      irq_vec;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .core_il(core_il), .irq_req(irq_req), .irq_lvl(irq_lvl), .irq_vec(irq_vec),
    .irq_take(irq_take));

  int checks = 0, fails = 0;
  logic [2:0] mlvl [NSRC];

  function automatic bit addr_ok(logic [15:0] a);
    logic [15:0] o = a - BASE;
    return !o[0] && (o >> 1) < 16'd10;
  endfunction

  function automatic logic [15:0] mread(logic [15:0] a);
    int k;
    if (!addr_ok(a)) return 16'h0;
    k = int'((a - BASE) >> 1);
    return {5'b0, mlvl[2*k+1], 5'b0, mlvl[2*k]};
  endfunction

  function automatic logic [11:0] arb(logic [NSRC-1:0] irq);
    logic [2:0] bl = 3'd0;
    int bi = 0;
    for (int i = 0; i < NSRC; i++)
      if (irq[i] && mlvl[i] > bl) begin bl = mlvl[i]; bi = i; end
    return (bl != 0) ? {1'b1, bl, 8'(VB + bi)} : 12'h0;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic [NSRC-1:0] irq, logic sel, logic wr, logic [15:0] a,
                      logic [15:0] wd, logic [2:0] il);
    logic [11:0] e;
    irq_in = irq; reg_sel = sel; reg_wr = wr; reg_addr = a; reg_wdata = wd; core_il = il;
    e = arb(irq);
    @(posedge clk);
    if (sel && wr && addr_ok(a)) begin
      int k = int'((a - BASE) >> 1);
      mlvl[2*k] = wd[2:0];
      mlvl[2*k+1] = wd[10:8];
    end
    @(negedge clk);
    chk("R5", "irq_req", int'(irq_req), int'(e[11]));
    chk("R5", "irq_lvl", int'(irq_lvl), int'(e[10:8]));
    chk("R6", "irq_vec", int'(irq_vec), int'(e[7:0]));
    chk("R8", "irq_take", int'(irq_take), int'(e[11] && e[10:8] > il));
    if (sel) chk("R3", "reg_rdata", int'(reg_rdata), int'(mread(a)));
  endtask

  task automatic wr_reg(int k, logic [15:0] d);
    step('0, 1'b1, 1'b1, BASE + 16'(2*k), d, 3'd0);
  endtask

  initial begin
    #(4 * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < NSRC; i++) mlvl[i] = 3'd0;
    rst_n = 1'b0; irq_in = '1; reg_sel = 0; reg_wr = 0; reg_addr = BASE; reg_wdata = 0; core_il = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "irq_req after reset", int'(irq_req), 0);
    for (int k = 0; k < 10; k++) begin
      reg_sel = 1; reg_addr = BASE + 16'(2*k); #1;
      chk("R1", "level reg after reset", int'(reg_rdata), 0);
    end
    @(negedge clk);

    // R2: all-ones writes keep only the two 3-bit fields
    for (int k = 0; k < 10; k++) wr_reg(k, 16'hFFFF);
    for (int k = 0; k < 10; k++) step('0, 1'b1, 1'b0, BASE + 16'(2*k), 16'h0, 3'd0);
    reg_addr = BASE + 16'd4; #1;
    chk("R2", "packed readback", int'(reg_rdata), 16'h0707);
    @(negedge clk);

    // R3: writes to invalid addresses do nothing, reads give zero
    step('0, 1'b1, 1'b1, BASE - 16'd2, 16'h0000, 3'd0);
    step('0, 1'b1, 1'b1, BASE + 16'd1, 16'h0000, 3'd0);
    step('0, 1'b1, 1'b1, BASE + 16'd20, 16'h0000, 3'd0);
    step('0, 1'b1, 1'b0, BASE + 16'd3, 16'h0, 3'd0);
    step('0, 1'b1, 1'b0, BASE, 16'h0, 3'd0);
    chk("R3", "reg 0 survived bad writes", int'(reg_rdata), 16'h0707);

    // R4: level 0 masks a source
    for (int k = 0; k < 10; k++) wr_reg(k, 16'h0000);
    step(20'hFFFFF, 1'b0, 1'b0, BASE, 16'h0, 3'd0);
    step(20'hFFFFF, 1'b0, 1'b0, BASE, 16'h0, 3'd0);
    chk("R4", "all-zero levels give no request", int'(irq_req), 0);

    // R5: tie goes to lowest index, higher level beats index
    wr_reg(1, 16'h0500);
    wr_reg(3, 16'h0500);
    wr_reg(6, 16'h0005);
    step(20'h01088, 1'b0, 1'b0, BASE, 16'h0, 3'd0);
    chk("R5", "tie lowest index", int'(irq_vec), VB + 3);
    wr_reg(6, 16'h0006);
    step(20'h01088, 1'b0, 1'b0, BASE, 16'h0, 3'd0);
    step(20'h01088, 1'b0, 1'b0, BASE, 16'h0, 3'd0);
    chk("R5", "higher level wins", int'(irq_vec), VB + 12);

    // R8: strict comparison against core_il
    step(20'h01000, 1'b0, 1'b0, BASE, 16'h0, 3'd6);
    chk("R8", "equal level held off", int'(irq_take), 0);
    step(20'h01000, 1'b0, 1'b0, BASE, 16'h0, 3'd5);
    chk("R8", "higher level accepted", int'(irq_take), 1);

    // R9: output changes only after the edge
    step('0, 1'b0, 1'b0, BASE, 16'h0, 3'd0);
    irq_in = 20'h00008; #1;
    chk("R9", "no change before edge", int'(irq_req), 0);
    step(20'h00008, 1'b0, 1'b0, BASE, 16'h0, 3'd0);
    chk("R9", "request after edge", int'(irq_req), 1);

    // R7: held line keeps presenting
    for (int n = 0; n < 4; n++) begin
      step(20'h00008, 1'b0, 1'b0, BASE, 16'h0, 3'd0);
      chk("R7", "held request re-presented", int'(irq_vec), VB + 3);
    end

    // random mix, level writes coinciding with arbitration
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] a;
      int r = int'($urandom_range(0, 9));
      a = (r < 7) ? BASE + 16'(2 * $urandom_range(0, 9))
        : (r == 7) ? BASE + 16'(2 * $urandom_range(0, 9)) + 16'd1
        : 16'($urandom());
      step(NSRC'($urandom()) & NSRC'($urandom()), 1'($urandom()), 1'($urandom()),
           a, 16'($urandom()), 3'($urandom()));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule